// File: doc/BRIEF.md
# Distributed Lookup-Table RAM with Optional Second Read Port

This block is a small random-access memory made entirely of 16-word by 1-bit storage cells. Each cell is written on the rising clock edge and read combinationally. A column of cells gives the word width. Several 16-deep banks stacked side by side give depths of 32, 64 or 128. The upper address bits pick the bank that is written, and a multiplexer on the bank outputs picks the read data.

Port A carries the only address used for writing, and it also reads from that address. When dual-port operation is selected, a second copy of the array is kept. It receives exactly the same writes as port A, but it is read through an independent port-B address, so port B can only read. When single-port operation is selected, port B is not built and its data output is tied low. Either read path can pass through an output register that shares the write clock, which turns the combinational read into a registered read.

Top module: `lutram_dp`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, the word at `addr_a` takes the value of `wdata`; the enable is active high.
- R2: `rdata_a` shows the word stored at `addr_a` within the same cycle, with no clock edge needed, when the output register is off.
- R3: While a write to `addr_a` is pending, `rdata_a` returns the old word up to the clock edge and the new word after it.
- R4: When `wr_en` is low at a clock edge, no stored word changes, whatever `wdata` holds.
- R5: Every address from 0 to DEPTH-1 is a separate word, including across the 16-word bank boundaries; writing one address leaves all the others unchanged.
- R6: In dual-port mode, `rdata_b` combinationally returns the word at `addr_b` from a copy whose contents always match port A's view.
- R7: `addr_b` never selects a write location; a write lands at `addr_a` even when `addr_b` points elsewhere.
- R8: In single-port mode, `rdata_b` is always zero and `addr_b` has no effect.
- R9: With the output register on, after each rising edge a read port shows the word that its address selected just before that edge, which means the value before that edge's write.
- R10: Reset is synchronous and active low. It clears the output registers only, and the stored words survive it.
- R11: At power-up, word w holds bits `INIT[w*WIDTH +: WIDTH]`. The default `INIT` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock and output-register clock |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| wr_en | input | 1 | Active-high write enable |
| addr_a | input | $clog2(DEPTH) | Port A read/write address |
| wdata | input | WIDTH | Write data |
| addr_b | input | $clog2(DEPTH) | Port B read-only address |
| rdata_a | output | WIDTH | Port A read data |
| rdata_b | output | WIDTH | Port B read data (zero in single-port mode) |

## Verification
A wrong cell bit, a bad bank decode or a stray write shows up at the read ports as soon as the affected address is presented: in the same cycle for combinational reads, and one edge later with the output register. If the two copies in dual-port mode drift apart, the mismatch appears whenever both ports point at that word. Full address sweeps with two data patterns reach every cell in both polarities. Read-during-write, write-disabled and reset cycles are then checked at the exact edge where each outcome must appear.

// File: rtl/lutram_pkg.sv
// Package: constants shared by the distributed-RAM modules.
// Assumes every storage cell is 16 words deep and 1 bit wide.
package lutram_pkg;
    localparam int CELL_DEPTH = 16;
    localparam int CELL_AW    = 4;

    // Number of 16-deep banks needed for a given depth.
    function automatic int bank_count(input int depth);
        return depth / CELL_DEPTH;
    endfunction
endpackage

// File: rtl/lutram_cell16.sv
// Module: lutram_cell16
// One 16x1 storage cell. Writes happen on the rising clock edge,
// and the read is purely combinational from its own read address.
// Assumes the power-up contents come from INIT, and that there is no reset of the bits.
module lutram_cell16 #(
    parameter logic [15:0] INIT = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [3:0] waddr,
    input  logic       wbit,
    input  logic [3:0] raddr,
    output logic       rbit
);
    logic [15:0] bits_q = INIT;

    // Store one bit at the write address when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            bits_q[waddr] <= wbit;
        end
    end

    // Combinational read of the addressed bit.
    assign rbit = bits_q[raddr];

    // R1
    cell_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (bits_q[$past(waddr)] == $past(wbit)));
endmodule

// File: rtl/lutram_array.sv
// Module: lutram_array
// DEPTH x WIDTH array built from 16x1 cells: one column of WIDTH cells per
// 16-deep bank. The upper write-address bits pick the bank that is written,
// and the upper read-address bits pick the bank that drives the read data.
// Assumes DEPTH is 16, 32, 64 or 128.
module lutram_array
    import lutram_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    parameter logic [DEPTH*WIDTH-1:0] INIT = '0,
    localparam int AW    = $clog2(DEPTH),
    localparam int BANKS = DEPTH / CELL_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [BANKS-1:0] bank_we;
    logic [WIDTH-1:0] bank_rd [BANKS];

    // Collect the 16 power-up bits of the cell for bank b and bit i.
    function automatic logic [15:0] cell_init(input int b, input int i);
        logic [15:0] r;
        for (int k = 0; k < CELL_DEPTH; k++) begin
            r[k] = INIT[(b*CELL_DEPTH + k)*WIDTH + i];
        end
        return r;
    endfunction

    generate
        if (BANKS == 1) begin : g_single_bank
            // A single bank is always selected.
            always_comb bank_we[0] = we;
            always_comb rdata = bank_rd[0];
        end else begin : g_multi_bank
            // Decode the upper write-address bits into per-bank enables.
            always_comb begin
                for (int b = 0; b < BANKS; b++) begin
                    bank_we[b] = we && (waddr[AW-1:CELL_AW] == b[AW-CELL_AW-1:0]);
                end
            end
            // Multiplex the bank outputs by the upper read-address bits.
            always_comb rdata = bank_rd[raddr[AW-1:CELL_AW]];
        end

        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                lutram_cell16 #(
                    .INIT (cell_init(b, i))
                ) u_cell (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .we    (bank_we[b]),
                    .waddr (waddr[CELL_AW-1:0]),
                    .wbit  (wdata[i]),
                    .raddr (raddr[CELL_AW-1:0]),
                    .rbit  (bank_rd[b][i])
                );
            end
        end
    endgenerate

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we ##1 $stable(raddr)) |-> $stable(rdata));
endmodule

// File: rtl/lutram_rdreg.sv
// Module: lutram_rdreg
// Optional read-data register on the memory clock. When ENABLE is 0 it is
// a wire. When ENABLE is 1 it captures the data every edge and is cleared by
// the synchronous active-low reset.
module lutram_rdreg #(
    parameter int WIDTH  = 8,
    parameter bit ENABLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (ENABLE) begin : g_reg
            logic [WIDTH-1:0] q_r;
            // Capture the read data, or clear it during reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d;
            end
            assign q = q_r;

            // R9
            rdreg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (q == $past(d)));
        end else begin : g_wire
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/lutram_dp.sv
// Module: lutram_dp (top)
// Distributed RAM with a read/write port A and an optional read-only port B.
// In dual-port mode a second array receives port A's writes and is read at
// addr_b. In single-port mode port B is absent and reads zero. Each read path
// can be registered with OUT_REG.
// Assumes DEPTH is 16, 32, 64 or 128.
module lutram_dp #(
    parameter int DEPTH     = 64,
    parameter int WIDTH     = 8,
    parameter bit DUAL_PORT = 1'b1,
    parameter bit OUT_REG   = 1'b0,
    parameter logic [DEPTH*WIDTH-1:0] INIT = '0,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr_a,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    addr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b
);
    logic [WIDTH-1:0] comb_a;
    logic [WIDTH-1:0] comb_b;

    lutram_array #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .INIT  (INIT)
    ) u_array_a (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (addr_a),
        .wdata (wdata),
        .raddr (addr_a),
        .rdata (comb_a)
    );

    generate
        if (DUAL_PORT) begin : g_dual
            // The copy shares port A's write address and data and reads at addr_b.
            lutram_array #(
                .DEPTH (DEPTH),
                .WIDTH (WIDTH),
                .INIT  (INIT)
            ) u_array_b (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (wr_en),
                .waddr (addr_a),
                .wdata (wdata),
                .raddr (addr_b),
                .rdata (comb_b)
            );

            // R6
            port_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (addr_a == addr_b) |-> (comb_a == comb_b));
        end else begin : g_single
            logic unused_addr_b;
            // Port B is absent, so its address is ignored.
            assign unused_addr_b = ^addr_b;
            assign comb_b = '0;
        end
    endgenerate

    lutram_rdreg #(
        .WIDTH  (WIDTH),
        .ENABLE (OUT_REG)
    ) u_rdreg_a (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (comb_a),
        .q     (rdata_a)
    );

    lutram_rdreg #(
        .WIDTH  (WIDTH),
        .ENABLE (OUT_REG)
    ) u_rdreg_b (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (comb_b),
        .q     (rdata_b)
    );
endmodule

// File: tb/lutram_dp_bench.sv
// Bench: three configurations share one stimulus. The main instance is a
// 32x4 dual-port RAM with combinational reads, the second is the same with
// registered reads, and the third is a 16x2 single-port RAM with a nonzero INIT.
module lutram_dp_bench;
    localparam logic [31:0] SP_INIT = 32'hA5C3_96F0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] addr_a = '0;
    logic [4:0] addr_b = '0;
    logic [3:0] wdata = '0;
    logic [3:0] rd_a, rd_b, rg_a, rg_b;
    logic [1:0] sp_a, sp_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [3:0] m [32];
    logic [1:0] s [16];
    logic [3:0] exp_ra, exp_rb;

    always #4 clk = ~clk;

    lutram_dp #(.DEPTH(32), .WIDTH(4), .DUAL_PORT(1'b1), .OUT_REG(1'b0)) u_lutram_dp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_a(addr_a), .wdata(wdata),
        .addr_b(addr_b), .rdata_a(rd_a), .rdata_b(rd_b));

    lutram_dp #(.DEPTH(32), .WIDTH(4), .DUAL_PORT(1'b1), .OUT_REG(1'b1)) u_lutram_dp_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_a(addr_a), .wdata(wdata),
        .addr_b(addr_b), .rdata_a(rg_a), .rdata_b(rg_b));

    lutram_dp #(.DEPTH(16), .WIDTH(2), .DUAL_PORT(1'b0), .OUT_REG(1'b0), .INIT(SP_INIT)) u_lutram_dp_sp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_a(addr_a[3:0]), .wdata(wdata[1:0]),
        .addr_b(addr_b[3:0]), .rdata_a(sp_a), .rdata_b(sp_b));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive the inputs (called just after a falling edge) and let them settle.
    task automatic drive(input logic we, input logic [4:0] a, input logic [4:0] b, input logic [3:0] d);
        wr_en = we; addr_a = a; addr_b = b; wdata = d;
        #1;
    endtask

    // One rising edge: predict the registered outputs, update the models, and return after the falling edge.
    task automatic tick();
        exp_ra = rst_n ? m[addr_a] : 4'h0;
        exp_rb = rst_n ? m[addr_b] : 4'h0;
        @(posedge clk);
        if (wr_en) begin
            m[addr_a] = wdata;
            s[addr_a[3:0]] = wdata[1:0];
        end
        @(negedge clk);
    endtask

    // Combinational reads of every instance against the models.
    task automatic check_reads(input string ra, input string rb);
        check(ra, {4'h0, rd_a}, {4'h0, m[addr_a]});
        check(rb, {4'h0, rd_b}, {4'h0, m[addr_b]});
        check("R8 single-port port A", {6'h0, sp_a}, {6'h0, s[addr_a[3:0]]});
        check("R8 single-port port B zero", {6'h0, sp_b}, 8'h0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 32; w++) m[w] = 4'h0;
        for (int w = 0; w < 16; w++) s[w] = SP_INIT[w*2 +: 2];

        // R10: the output registers are clear while reset is held.
        @(negedge clk);
        drive(1'b0, 5'd0, 5'd0, 4'h0);
        tick();
        tick();
        check("R10 reset reg A", {4'h0, rg_a}, 8'h0);
        check("R10 reset reg B", {4'h0, rg_b}, 8'h0);
        rst_n = 1'b1;

        // R11: the power-up contents follow INIT (zero for the main instance).
        for (int a = 0; a < 32; a++) begin
            drive(1'b0, 5'(a), 5'(31 - a), 4'h0);
            check_reads("R11 init A", "R11 init B");
        end

        // R1, R5, R9: sweep writes and reads with two bit patterns.
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < 32; a++) begin
                drive(1'b1, 5'(a), 5'((a + 16) % 32), (p == 0) ? 4'((a*7 + 3) & 15) : ~4'((a*7 + 3) & 15));
                tick();
            end
            for (int a = 0; a < 32; a++) begin
                drive(1'b0, 5'(a), 5'((a*3 + p) % 32), 4'h0);
                check_reads("R1 R5 R2 sweep A", "R6 sweep B");
                tick();
                check("R9 reg A", {4'h0, rg_a}, {4'h0, exp_ra});
                check("R9 reg B", {4'h0, rg_b}, {4'h0, exp_rb});
            end
        end

        // R3: a read during a write returns old data, then new data after the edge.
        begin
            logic [3:0] old5;
            old5 = m[5];
            drive(1'b1, 5'd5, 5'd5, ~old5);
            check("R3 before edge A", {4'h0, rd_a}, {4'h0, old5});
            check("R3 before edge B", {4'h0, rd_b}, {4'h0, old5});
            tick();
            check("R9 reg shows pre-write", {4'h0, rg_a}, {4'h0, old5});
            drive(1'b0, 5'd5, 5'd5, 4'h0);
            check("R3 after edge A", {4'h0, rd_a}, {4'h0, ~old5});
            check("R6 after edge B", {4'h0, rd_b}, {4'h0, ~old5});
        end

        // R4: with the enable low, the data input is ignored.
        drive(1'b0, 5'd9, 5'd25, ~m[9]);
        tick();
        drive(1'b0, 5'd9, 5'd25, 4'h0);
        check_reads("R4 no write A", "R4 no write B");

        // R7: addr_b never steers a write.
        drive(1'b1, 5'd3, 5'd20, ~m[3]);
        tick();
        check("R7 addr_b location kept", {4'h0, rd_b}, {4'h0, m[20]});
        drive(1'b0, 5'd20, 5'd3, 4'h0);
        check_reads("R7 read A", "R7 written at addr_a");

        // R10: reset clears the registers but not the contents.
        rst_n = 1'b0;
        drive(1'b0, 5'd17, 5'd2, 4'h0);
        tick();
        check("R10 reg A in reset", {4'h0, rg_a}, 8'h0);
        check("R10 reg B in reset", {4'h0, rg_b}, 8'h0);
        check_reads("R10 contents kept A", "R10 contents kept B");
        rst_n = 1'b1;
        tick();
        check("R10 reg after reset", {4'h0, rg_a}, {4'h0, m[17]});

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule